// File: doc/BRIEF.md
# Nonvolatile Memory Write-Protect Controller

This block sits between a register bus and the write path of an emulated nonvolatile byte array. It holds a small protection setting with an enable flag and a two-bit region code. For every write or erase request on the memory side it decides in the same cycle whether the target byte may be changed. The protected region always starts at the top of the array and grows downward in quarter steps.

A separate lock flag, once set, freezes the protection setting until the next reset. The lock is also driven out on `lock_o`, so that neighbouring protection registers outside this block can use the same freeze.

The memory-side request channel has no back-pressure. Each cycle with `mem_req` high is one request, and the block answers it in that same cycle. A denied request never reaches the array, because `mem_we` stays low, and one cycle later it raises a single-cycle violation flag. The register bus is plain: writes take effect at the clock edge, and read data is combinational while `reg_rd` is high.

Top module: `nvm_wrprot_ctrl`

## Requirements
- R1: After reset the enable flag, the region code and the lock are all 0. `lock_o` is low, and every memory request is allowed.
- R2: A register write with `reg_blk` = 3'b000 and `reg_addr` = 0xE2 loads bit 2 as the enable flag and bits 1:0 as the region code. The new value governs decisions from the next cycle on.
- R3: A read at block 000, address 0xE2 returns the enable flag on bit 2, the region code on bits 1:0 and 0 on bits 7:3. Written values on bits 7:3 are discarded.
- R4: While the enable flag is 0, every memory address is allowed, whatever the region code holds.
- R5: While the enable flag is 1, the region code protects part of the array. Code 00 protects the top quarter, 01 the top half, 10 the top three quarters, and 11 the whole array. With DEPTH bytes, an address is protected when it is at least (3 − code)·DEPTH/4.
- R6: The lock lives at block 000, address 0xE3, bit 0. Writing 1 to bit 0 sets it, and writing 0 does not clear it. Only reset clears it. It reads back on bit 0 with bits 7:1 at 0, and it drives `lock_o`.
- R7: While the lock is 1, writes to address 0xE2 leave the protection setting unchanged.
- R8: `mem_allow` is high exactly when `mem_addr` is not protected. `mem_we` equals `mem_req` AND `mem_allow` in the same cycle.
- R9: `viol` is high for one cycle in the cycle after each cycle where `mem_req` was high and the address was protected. Otherwise it is low.
- R10: `reg_rdata` is 0 when `reg_rd` is low, when `reg_blk` is not 000, or when the address is neither 0xE2 nor 0xE3. Writes to such places change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_blk | input | 3 | Register bus block select |
| reg_addr | input | 8 | Register bus word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_req | input | 1 | Write/erase request valid this cycle |
| mem_addr | input | AW | Byte address of the request |
| mem_allow | output | 1 | Address is writable under the current setting |
| mem_we | output | 1 | Gated write enable toward the array |
| viol | output | 1 | One-cycle flag for a denied request, one cycle late |
| lock_o | output | 1 | Lock state for neighbouring registers |

## Verification
The hardest situation to reach is an attempt to rewrite the protection setting after the lock is set. It matters most when the attempted value would widen or drop protection, and when it is followed by requests at the exact quarter boundaries. Without a reset in between, such a run shows nothing. The stimulus therefore mixes random register traffic with occasional lock writes and periodic resets, so that locked and unlocked epochs alternate. Directed runs also probe the addresses one below and one at each quarter boundary, for every region code.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef struct packed {
    logic       en;
    logic [1:0] sel;
  } wp_cfg_t;

  localparam logic [2:0] WP_BLK_ID    = 3'b000;
  localparam logic [7:0] WP_PROT_ADDR = 8'hE2;
  localparam logic [7:0] WP_LOCK_ADDR = 8'hE3;
endpackage

// File: rtl/wp_regs.sv
module wp_regs
  import wp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_blk,
  input  logic [7:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output wp_cfg_t       cfg_o,
  output logic          lock_o
);
  logic    blk_hit, hit_prot, hit_lock;
  wp_cfg_t cfg_q;
  logic    lock_q;

  assign blk_hit  = (reg_blk == WP_BLK_ID);
  assign hit_prot = blk_hit && (reg_addr == WP_PROT_ADDR);
  assign hit_lock = blk_hit && (reg_addr == WP_LOCK_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (reg_wr && hit_prot && !lock_q)
        cfg_q <= wp_cfg_t'(reg_wdata[2:0]);
      if (reg_wr && hit_lock && reg_wdata[0])
        lock_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_rd && hit_prot) reg_rdata = {5'b0, cfg_q};
    else if (reg_rd && hit_lock) reg_rdata = {7'b0, lock_q};
  end

  assign cfg_o  = cfg_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/wp_region.sv
module wp_region
  import wp_pkg::*;
#(
  parameter int AW = 8
) (
  input  wp_cfg_t       cfg,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [1:0] quarter;
  logic [1:0] floor_q;

  assign quarter = addr[AW-1 -: 2];
  assign floor_q = 2'd3 - cfg.sel;
  assign hit     = cfg.en && (quarter >= floor_q);
endmodule

// File: rtl/nvm_wrprot_ctrl.sv
module nvm_wrprot_ctrl
  import wp_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_blk,
  input  logic [7:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          mem_req,
  input  logic [AW-1:0] mem_addr,
  output logic          mem_allow,
  output logic          mem_we,
  output logic          viol,
  output logic          lock_o
);
  wp_cfg_t cfg_q;
  logic    prot_hit;
  logic    viol_q;

  wp_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_blk(reg_blk), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_o(cfg_q), .lock_o(lock_o)
  );

  wp_region #(.AW(AW)) u_region (
    .cfg(cfg_q), .addr(mem_addr), .hit(prot_hit)
  );

  assign mem_allow = !prot_hit;
  assign mem_we    = mem_req && mem_allow;

  always_ff @(posedge clk) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= mem_req && prot_hit;
  end

  assign viol = viol_q;
endmodule

// File: rtl/nvm_wrprot_chk.sv
module nvm_wrprot_chk
  import wp_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    reg_blk,
  input logic [7:0]    reg_addr,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [7:0]    reg_rdata,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_allow,
  input logic          mem_we,
  input logic          viol,
  input logic          lock_o,
  input wp_cfg_t       cfg_q
);
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> lock_o); // R6
  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> $stable(cfg_q)); // R7
  AST_OFF_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.en |-> mem_allow); // R4
  AST_FULL_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.en && cfg_q.sel == 2'b11) |-> !mem_allow); // R5
  AST_TOP_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.en && (&mem_addr)) |-> !mem_allow); // R5
  AST_GATED_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_allow |-> !mem_we); // R8
  AST_VIOL_AFTER_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_allow) |=> viol); // R9
  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_allow) |=> !viol); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_blk == WP_BLK_ID && reg_addr == WP_PROT_ADDR) |-> reg_rdata[7:3] == 5'b0); // R3
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == 8'h00); // R10
endmodule

bind nvm_wrprot_ctrl nvm_wrprot_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_blk(reg_blk), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_allow(mem_allow),
  .mem_we(mem_we), .viol(viol), .lock_o(lock_o), .cfg_q(cfg_q)
);

// File: tb/nvm_wrprot_ctrl_bench.sv
module nvm_wrprot_ctrl_bench;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    reg_blk = '0;
  logic [7:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          mem_req = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic          mem_allow, mem_we, viol, lock_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [2:0] m_prot;
  logic       m_lock;
  logic       m_viol;

  always #4 clk = ~clk;

  nvm_wrprot_ctrl #(.DEPTH(DEPTH)) u_nvm_wrprot_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_blk(reg_blk), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_allow(mem_allow),
    .mem_we(mem_we), .viol(viol), .lock_o(lock_o)
  );

  function automatic logic exp_protected(logic [2:0] p, int a);
    if (!p[2]) return 1'b0;
    return a >= (3 - int'(p[1:0])) * (DEPTH / 4);
  endfunction

  function automatic logic [7:0] exp_rdata(logic [2:0] b, logic [7:0] a, logic rd);
    if (!rd || b != 3'b000) return 8'h00;
    if (a == 8'hE2) return {5'b0, m_prot};
    if (a == 8'hE3) return {7'b0, m_lock};
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [2:0] b, logic [7:0] a, logic wr, logic rd,
                     logic [7:0] wd, logic rq, logic [AW-1:0] ma);
    logic ea;
    @(negedge clk);
    chk("R9 viol", {7'b0, viol}, {7'b0, m_viol});
    chk("R6 lock_o", {7'b0, lock_o}, {7'b0, m_lock});
    reg_blk = b; reg_addr = a; reg_wr = wr; reg_rd = rd; reg_wdata = wd;
    mem_req = rq; mem_addr = ma;
    #1;
    ea = !exp_protected(m_prot, int'(ma));
    chk("R8 mem_allow (R4 R5)", {7'b0, mem_allow}, {7'b0, ea});
    chk("R8 mem_we", {7'b0, mem_we}, {7'b0, rq && ea});
    chk("R3 R10 reg_rdata", reg_rdata, exp_rdata(b, a, rd));
    @(posedge clk);
    if (wr && b == 3'b000) begin
      if (a == 8'hE2 && !m_lock) m_prot = wd[2:0];
      if (a == 8'hE3 && wd[0]) m_lock = 1'b1;
    end
    m_viol = rq && !ea;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; mem_req = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_prot = '0; m_lock = 1'b0; m_viol = 1'b0;
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    cyc(3'b000, a, 1'b1, 1'b0, d, 1'b0, '0);
  endtask

  task automatic rd_reg(logic [7:0] a);
    cyc(3'b000, a, 1'b0, 1'b1, 8'h00, 1'b0, '0);
  endtask

  task automatic probe_bounds();
    for (int q = 1; q < 4; q++) begin
      cyc(3'b000, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, AW'(q * DEPTH / 4 - 1));
      cyc(3'b000, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, AW'(q * DEPTH / 4));
    end
    cyc(3'b000, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, AW'(0));
    cyc(3'b000, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, AW'(DEPTH - 1));
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_prot = '0; m_lock = 1'b0; m_viol = 1'b0;
    do_reset();
    // R1: reset state
    rd_reg(8'hE2);
    rd_reg(8'hE3);
    probe_bounds();
    // R4: enable off, every region code
    for (int s = 0; s < 4; s++) begin
      wr_reg(8'hE2, 8'(s));
      probe_bounds();
    end
    // R2 R5: enabled, every region code, with junk on upper bits (R3)
    for (int s = 0; s < 4; s++) begin
      wr_reg(8'hE2, 8'hF8 | 8'(4 + s));
      rd_reg(8'hE2);
      probe_bounds();
    end
    // R10: wrong block and unmapped address writes change nothing
    cyc(3'b001, 8'hE2, 1'b1, 1'b0, 8'h00, 1'b0, '0);
    cyc(3'b000, 8'hE1, 1'b1, 1'b0, 8'h00, 1'b0, '0);
    cyc(3'b010, 8'hE2, 1'b0, 1'b1, 8'h00, 1'b0, '0);
    rd_reg(8'hE2);
    // R6: writing 0 does not set, writing 1 sets, writing 0 does not clear
    wr_reg(8'hE2, 8'h04);
    wr_reg(8'hE3, 8'hFE);
    rd_reg(8'hE3);
    wr_reg(8'hE3, 8'h01);
    rd_reg(8'hE3);
    wr_reg(8'hE3, 8'h00);
    rd_reg(8'hE3);
    // R7: locked setting cannot widen or drop protection
    wr_reg(8'hE2, 8'h07);
    rd_reg(8'hE2);
    probe_bounds();
    wr_reg(8'hE2, 8'h00);
    probe_bounds();
    // R1: reset clears lock
    do_reset();
    rd_reg(8'hE3);
    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic [2:0] b;
      logic [7:0] a;
      int pick;
      if (i % 700 == 699) do_reset();
      pick = int'($urandom_range(0, 9));
      b = (pick == 0) ? 3'($urandom) : 3'b000;
      case ($urandom_range(0, 5))
        0, 1, 2: a = 8'hE2;
        3:       a = 8'hE3;
        default: a = 8'($urandom);
      endcase
      cyc(b, a,
          ($urandom_range(0, 3) == 0) && !(a == 8'hE3 && $urandom_range(0, 7) != 0),
          1'($urandom), 8'($urandom), 1'($urandom), AW'($urandom));
    end
    cyc(3'b000, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, '0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule